// File: doc/BRIEF.md
# 100BASE-TX Receive Code-Group Decoder

This block sits between the descrambler and the MII receive side of a 100 Mb/s physical layer. It accepts one aligned, descrambled 5-bit code group on every receive clock. It turns data code groups back into 4-bit receive nibbles. It also generates carrier sense, receive data valid and receive error from the delimiter and idle rules, so it does more than a plain table lookup.

A frame opens with the start pair J,K. While that pair is received, the nibble output carries the preamble value 0101, so the frame delivered to the MAC starts with valid preamble. A frame closes with the end pair T,R. A broken start pair, a broken end pair, a frame that stops on idle, and code groups that are not valid all raise the receive error output.

A mode input selects 10 Mb/s behaviour. In that mode, data valid simply follows carrier sense, and the nibble and error outputs keep their normal rules. All outputs are registered, so each one reflects the code group that was present one clock earlier.

Top module: `rx_symbol_decoder`

## Requirements
- R1: `crs_o` is 1 in the cycle after any code group other than IDLE (11111) is presented, and 0 in the cycle after IDLE.
- R2: The start pair is J (11000) followed by K (10001). The output cycle for J shows `rxd_o`=0101 with `rxdv_o`=0. The output cycle for K shows `rxd_o`=0101 with `rxdv_o`=1, and the frame begins there.
- R3: Inside a frame, each data code group from the standard 4B/5B table (0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101) gives its nibble on `rxd_o`, with `rxdv_o`=1 and `rxer_o`=0.
- R4: Inside a frame, T (01101) drops `rxdv_o` to 0 in its own output cycle. If R (00111) follows, `rxer_o` stays 0 and the decoder returns to idle.
- R5: IDLE received inside a frame ends the frame. That cycle shows `rxdv_o`=0 and `rxer_o`=1.
- R6: Inside a frame, any code group that is neither data, T nor IDLE gives `rxer_o`=1, `rxdv_o`=1 and `rxd_o`=0000, and the frame continues.
- R7: A J that is not followed by K gives `rxer_o`=1 for exactly that following cycle, with `rxdv_o`=0.
- R8: A T that is not followed by R gives `rxer_o`=1 for exactly that following cycle, with `rxdv_o`=0.
- R9: Outside a frame, a code group that is neither IDLE nor J is a false carrier. It gives `rxer_o`=1 for one cycle. After that, every code group, J included, produces `rxer_o`=0 and `rxdv_o`=0 until an IDLE is seen.
- R10: With `mode_10m`=1, `rxdv_o` equals `crs_o`, and `rxd_o` and `rxer_o` follow the same rules as in 100 Mb/s mode.
- R11: `rst_n` low at a clock edge (synchronous, active low) clears `crs_o`, `rxdv_o`, `rxer_o` and `rxd_o` to 0 and returns the decoder to idle.
- R12: Outside a frame, `rxd_o` is 0000 except in the output cycles of the start pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_10m | input | 1 | 1 selects 10 Mb/s valid behaviour |
| code_i | input | 5 | Aligned, descrambled code group |
| rxd_o | output | 4 | Receive nibble |
| crs_o | output | 1 | Carrier sense |
| rxdv_o | output | 1 | Receive data valid |
| rxer_o | output | 1 | Receive error |

## Verification
The bench presents every ordered pair of the 32 code groups in two positions: right after a start pair plus one data nibble, and straight out of idle. It repeats this in both modes. These sweeps reach the following corner cases:
- A J followed by J, which a design with loose pair handling would accept as a start.
- A T followed by a non-R, where a design could leave the error line silent.
- A J arriving during a false carrier, which a design might wrongly treat as the start of a frame.
- An idle inside a frame, where a design could drop valid without signalling the error.

A reset applied in the middle of a frame must clear every output. If it does not, stale valid or error levels appear.

// File: rtl/rxsym_pkg.sv
// Package: shared constants, code-group classes, decoder states and the
// 4B/5B data encoding used by the receive decoder.
package rxsym_pkg;
    localparam int CG_W  = 5;
    localparam int NIB_W = 4;
    localparam int NUM_DATA = 1 << NIB_W;

    localparam logic [CG_W-1:0]  CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0]  CG_J    = 5'b11000;
    localparam logic [CG_W-1:0]  CG_K    = 5'b10001;
    localparam logic [CG_W-1:0]  CG_T    = 5'b01101;
    localparam logic [CG_W-1:0]  CG_R    = 5'b00111;
    localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;

    typedef enum logic [2:0] {
        CK_DATA, CK_IDLE, CK_J, CK_K, CK_T, CK_R, CK_BAD
    } cg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SAW_J, ST_FRAME, ST_SAW_T, ST_FALSE
    } rx_state_e;

    // Data nibble to its 5-bit code group.
    function automatic logic [CG_W-1:0] data_code(input logic [NIB_W-1:0] n);
        case (n)
            4'h0: data_code = 5'b11110;
            4'h1: data_code = 5'b01001;
            4'h2: data_code = 5'b10100;
            4'h3: data_code = 5'b10101;
            4'h4: data_code = 5'b01010;
            4'h5: data_code = 5'b01011;
            4'h6: data_code = 5'b01110;
            4'h7: data_code = 5'b01111;
            4'h8: data_code = 5'b10010;
            4'h9: data_code = 5'b10011;
            4'hA: data_code = 5'b10110;
            4'hB: data_code = 5'b10111;
            4'hC: data_code = 5'b11010;
            4'hD: data_code = 5'b11011;
            4'hE: data_code = 5'b11100;
            default: data_code = 5'b11101;
        endcase
    endfunction
endpackage

// File: rtl/rxsym_lookup.sv
// Module: rxsym_lookup
// Classifies one code group and recovers its data nibble.
// Assumes the input is already aligned and descrambled. Purely combinational.
module rxsym_lookup
    import rxsym_pkg::*;
(
    input  logic [CG_W-1:0]  code,
    output cg_kind_e         kind,
    output logic [NIB_W-1:0] nib
);
    logic              hit;
    logic [NIB_W-1:0]  hit_nib;

    // Search the data table for a match.
    always_comb begin
        hit     = 1'b0;
        hit_nib = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (data_code(NIB_W'(i)) == code) begin
                hit     = 1'b1;
                hit_nib = NIB_W'(i);
            end
        end
    end

    // Assign a class to the code group.
    always_comb begin
        if (hit)                 kind = CK_DATA;
        else if (code == CG_IDLE) kind = CK_IDLE;
        else if (code == CG_J)    kind = CK_J;
        else if (code == CG_K)    kind = CK_K;
        else if (code == CG_T)    kind = CK_T;
        else if (code == CG_R)    kind = CK_R;
        else                      kind = CK_BAD;
        nib = hit_nib;
    end

    // R3: a recovered nibble must re-encode to the same code group.
    always_comb begin
        if (kind == CK_DATA)
            a_r3_nibble_roundtrip: assert (data_code(nib) == code);
    end
endmodule

// File: rtl/rxsym_frame_fsm.sv
// Module: rxsym_frame_fsm
// Tracks delimiters and frame state and registers the MII receive outputs.
// Assumes one classified code group per clock. Reset is synchronous and active low.
module rxsym_frame_fsm
    import rxsym_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_10m,
    input  cg_kind_e         kind,
    input  logic [NIB_W-1:0] nib,
    output logic [NIB_W-1:0] rxd_q,
    output logic             crs_q,
    output logic             dv_q,
    output logic             er_q
);
    rx_state_e        st, st_n;
    logic             dv_n, er_n;
    logic [NIB_W-1:0] nib_n;

    // Next state and next output values from the state and the code-group class.
    always_comb begin
        st_n  = st;
        dv_n  = 1'b0;
        er_n  = 1'b0;
        nib_n = '0;
        case (st)
            ST_IDLE: begin
                if (kind == CK_J) begin
                    st_n  = ST_SAW_J;
                    nib_n = PRE_NIB;
                end else if (kind != CK_IDLE) begin
                    st_n = ST_FALSE;
                    er_n = 1'b1;
                end
            end
            ST_SAW_J: begin
                if (kind == CK_K) begin
                    st_n  = ST_FRAME;
                    dv_n  = 1'b1;
                    nib_n = PRE_NIB;
                end else begin
                    er_n = 1'b1;
                    st_n = (kind == CK_IDLE) ? ST_IDLE : ST_FALSE;
                end
            end
            ST_FRAME: begin
                case (kind)
                    CK_DATA: begin
                        dv_n  = 1'b1;
                        nib_n = nib;
                    end
                    CK_T:    st_n = ST_SAW_T;
                    CK_IDLE: begin
                        er_n = 1'b1;
                        st_n = ST_IDLE;
                    end
                    default: begin
                        dv_n = 1'b1;
                        er_n = 1'b1;
                    end
                endcase
            end
            ST_SAW_T: begin
                if (kind == CK_R) begin
                    st_n = ST_IDLE;
                end else begin
                    er_n = 1'b1;
                    st_n = (kind == CK_IDLE) ? ST_IDLE : ST_FALSE;
                end
            end
            default: begin
                if (kind == CK_IDLE) st_n = ST_IDLE;
            end
        endcase
        if (mode_10m) dv_n = (kind != CK_IDLE);
    end

    // Register the state and all receive outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            rxd_q <= '0;
            crs_q <= 1'b0;
            dv_q  <= 1'b0;
            er_q  <= 1'b0;
        end else begin
            st    <= st_n;
            rxd_q <= nib_n;
            crs_q <= (kind != CK_IDLE);
            dv_q  <= dv_n;
            er_q  <= er_n;
        end
    end

    // R6: whenever error is reported, the nibble is all zero.
    a_r6_error_zero_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        er_q |-> rxd_q == '0);

    // R2: in 100 Mb/s mode, valid rises only together with the preamble nibble.
    a_r2_dv_rise_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mode_10m) && $rose(dv_q)) |-> rxd_q == PRE_NIB);

    // R1: valid never stands without carrier.
    a_r1_dv_needs_crs: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q |-> crs_q);

    // R10: in 10 Mb/s mode, valid tracks carrier sense.
    a_r10_dv_is_crs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_10m)) |-> dv_q == crs_q);

    // R9: the false-carrier state holds until idle arrives.
    a_r9_false_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FALSE && kind != CK_IDLE) |=> st == ST_FALSE);
endmodule

// File: rtl/rx_symbol_decoder.sv
// Module: rx_symbol_decoder (top)
// Turns aligned, descrambled 5-bit code groups into MII receive nibbles and
// carrier sense, data valid and receive error. Output latency is one clock.
module rx_symbol_decoder
    import rxsym_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_10m,
    input  logic [CG_W-1:0]  code_i,
    output logic [NIB_W-1:0] rxd_o,
    output logic             crs_o,
    output logic             rxdv_o,
    output logic             rxer_o
);
    cg_kind_e         kind;
    logic [NIB_W-1:0] nib;

    rxsym_lookup u_lookup (
        .code (code_i),
        .kind (kind),
        .nib  (nib)
    );

    rxsym_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_10m (mode_10m),
        .kind     (kind),
        .nib      (nib),
        .rxd_q    (rxd_o),
        .crs_q    (crs_o),
        .dv_q     (rxdv_o),
        .er_q     (rxer_o)
    );

    // R1: carrier sense reflects whether the previous code group was non-idle.
    a_r1_crs_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> crs_o == ($past(code_i) != CG_IDLE));

    // R11: a clock edge that sees reset leaves every output cleared.
    a_r11_reset_clears: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 |->
            !crs_o && !rxdv_o && !rxer_o && rxd_o == '0);
endmodule

// File: tb/rx_symbol_decoder_tb.sv
module rx_symbol_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_10m = 1'b0;
    logic [4:0] code_i = 5'b11111;
    logic [3:0] rxd_o;
    logic       crs_o, rxdv_o, rxer_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state: 0 idle, 1 saw J, 2 frame, 3 saw T, 4 false carrier
    int ms = 0;
    logic [3:0] e_rxd;
    logic e_crs, e_dv, e_er;
    string e_tag;

    localparam logic [4:0] IDL = 5'b11111, CJ = 5'b11000, CK = 5'b10001,
                           CT = 5'b01101, CR = 5'b00111;

    rx_symbol_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode_10m(mode_10m), .code_i(code_i),
        .rxd_o(rxd_o), .crs_o(crs_o), .rxdv_o(rxdv_o), .rxer_o(rxer_o)
    );

    always #2 clk = ~clk;

    // Return the nibble that code c carries, or -1 if c is not a data code group.
    function automatic int dec(input logic [4:0] c);
        logic [4:0] tbl [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B,
                                 5'h0E, 5'h0F, 5'h12, 5'h13, 5'h16, 5'h17,
                                 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        dec = -1;
        for (int i = 0; i < 16; i++) if (tbl[i] == c) dec = i;
    endfunction

    function automatic logic [4:0] enc(input int n);
        logic [4:0] tbl [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B,
                                 5'h0E, 5'h0F, 5'h12, 5'h13, 5'h16, 5'h17,
                                 5'h1A, 5'h1B, 5'h1C, 5'h1D};
        enc = tbl[n & 15];
    endfunction

    // Work out the expected outputs for code c from the requirements, then advance the model.
    task automatic model(input logic [4:0] c);
        int d = dec(c);
        int nx = ms;
        e_rxd = 4'h0; e_dv = 0; e_er = 0; e_crs = (c != IDL);
        e_tag = "R12";
        case (ms)
            0: if (c == CJ) begin nx = 1; e_rxd = 4'b0101; e_tag = "R2"; end
               else if (c != IDL) begin nx = 4; e_er = 1; e_tag = "R9"; end
            1: if (c == CK) begin nx = 2; e_dv = 1; e_rxd = 4'b0101; e_tag = "R2"; end
               else begin e_er = 1; nx = (c == IDL) ? 0 : 4; e_tag = "R7"; end
            2: if (d >= 0) begin e_dv = 1; e_rxd = 4'(d); e_tag = "R3"; end
               else if (c == CT) begin nx = 3; e_tag = "R4"; end
               else if (c == IDL) begin e_er = 1; nx = 0; e_tag = "R5"; end
               else begin e_dv = 1; e_er = 1; e_tag = "R6"; end
            3: if (c == CR) begin nx = 0; e_tag = "R4"; end
               else begin e_er = 1; nx = (c == IDL) ? 0 : 4; e_tag = "R8"; end
            default: begin e_tag = "R9"; if (c == IDL) nx = 0; end
        endcase
        if (mode_10m) begin e_dv = e_crs; e_tag = "R10"; end
        ms = nx;
    endtask

    task automatic check(input string tag);
        n_cmp++;
        if (crs_o !== e_crs) begin
            n_bad++;
            $display("FAIL R1 (%s) crs=%b expected %b", tag, crs_o, e_crs);
        end else if (rxdv_o !== e_dv || rxer_o !== e_er || rxd_o !== e_rxd) begin
            n_bad++;
            $display("FAIL %s dv/er/rxd=%b/%b/%h expected %b/%b/%h",
                     tag, rxdv_o, rxer_o, rxd_o, e_dv, e_er, e_rxd);
        end
    endtask

    // Present one code group and compare outputs one clock later.
    task automatic step(input logic [4:0] c);
        code_i = c;
        model(c);
        @(posedge clk); #1;
        check(e_tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset with non-idle input keeps outputs cleared
        code_i = CJ;
        repeat (3) @(posedge clk);
        #1;
        e_rxd = 0; e_crs = 0; e_dv = 0; e_er = 0;
        check("R11");
        rst_n = 1'b1;
        ms = 0;
        for (int m = 0; m < 2; m++) begin
            mode_10m = m[0];
            for (int a = 0; a < 32; a++) begin
                for (int b = 0; b < 32; b++) begin
                    step(IDL); step(IDL);
                    step(CJ); step(CK); step(enc(a)); step(5'(a)); step(5'(b));
                    step(IDL); step(IDL);
                    step(5'(a)); step(5'(b)); step(IDL);
                end
            end
        end
        // R11: reset in the middle of a frame clears every output
        mode_10m = 1'b0;
        step(IDL); step(CJ); step(CK); step(enc(5));
        rst_n = 1'b0;
        code_i = enc(9);
        @(posedge clk); #1;
        e_rxd = 0; e_crs = 0; e_dv = 0; e_er = 0;
        check("R11");
        rst_n = 1'b1;
        ms = 0;
        step(enc(9));   // R9: data after reset is a false carrier
        step(IDL);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule